// File: doc/BRIEF.md
# Multicontext Encoded-Select Routing Crossbar

This block is a sixteen-input, eight-output routing switch whose connection pattern is chosen per cycle from one of four stored routings. Each routing is kept as a compact 32-bit word that holds one 4-bit selector per output. It is not held as one bit per crosspoint. The word of the active context is decoded into one-hot crosspoint enables, and each output is the OR of the inputs its enables admit.

The routing context is picked by a 2-bit context number. This number may change on every cycle, and the path from data inputs and context number to the outputs is purely combinational. A programming port writes a new word into any context on a clock edge. If the written context is the active one, the new routing appears from the next cycle.

Top module: `ctx_xbar`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every context holds an all-zero word, so every output follows input 0 whichever context is selected.
- R2: In a routing word, output k is driven by the input whose index is held in bits [4k+3:4k].
- R3: The routing word used is the one stored for the context given by ctx_sel. A change of ctx_sel takes effect in the same cycle, with no added latency, and may occur on every cycle.
- R4: When prog_we is high at a clock edge, prog_word is stored into context prog_ctx. If that context is active, the outputs keep the old routing until the edge and use the new routing from the next cycle.
- R5: A write to one context leaves the words of the other three contexts unchanged.
- R6: For every output, exactly one of the sixteen crosspoint enables is active in every cycle. A single input set high therefore reaches exactly the outputs that select it.
- R7: While no write occurs, the stored routings hold their values. With ctx_sel and din stable, dout is stable.
- R8: A change on din appears on dout within the same cycle, without a clock edge.
- R9: Several outputs may select the same input, and then all of them carry that input's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Synchronous active-low reset of the configuration store |
| ctx_sel | input | 2 | Active context number |
| din | input | 16 | Input signals to be routed |
| prog_we | input | 1 | Configuration write strobe |
| prog_ctx | input | 2 | Context number to write |
| prog_word | input | 32 | Encoded routing word, 4 bits per output |
| dout | output | 8 | Routed output signals |

## Verification
Two operations can coincide in one cycle: a configuration write, and routing through the same context that is being written. To provoke this, the bench selects a context and, in that same cycle, writes a different word into it. It checks dout before the edge against the old word and after the edge against the new one. The bench also writes to an inactive context while routing through the active one, and judges that the active outputs and the other stored words stay unchanged.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Default geometry of the switch
    localparam int unsigned DEF_N_IN  = 16;
    localparam int unsigned DEF_N_OUT = 8;
    localparam int unsigned DEF_N_CTX = 4;

    // Selector width able to name any of n inputs (at least one bit)
    function automatic int unsigned sel_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) < n) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store #(
    parameter int unsigned N_CTX = 4,
    parameter int unsigned CFG_W = 32,
    localparam int unsigned CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [CFG_W-1:0] wr_word,
    input  logic [CTX_W-1:0] rd_ctx,
    output logic [CFG_W-1:0] rd_word
);

    typedef struct packed {
        logic [N_CTX-1:0][CFG_W-1:0] word;
    } store_t;

    store_t state_d;
    store_t state_q;

    always_comb begin
        state_d = state_q;
        for (int c = 0; c < N_CTX; c++) begin
            if (wr_en && (wr_ctx == CTX_W'(c))) begin
                state_d.word[c] = wr_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Combinational read of the active context
    assign rd_word = state_q.word[rd_ctx];

endmodule

// File: rtl/xbar_sel_decode.sv
module xbar_sel_decode #(
    parameter int unsigned N_IN  = 16,
    parameter int unsigned N_OUT = 8,
    parameter int unsigned SEL_W = 4,
    localparam int unsigned CFG_W = N_OUT * SEL_W
) (
    input  logic [CFG_W-1:0]            word,
    output logic [N_OUT-1:0][N_IN-1:0]  en
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [SEL_W-1:0] field;
        assign field = word[k*SEL_W +: SEL_W];

        always_comb begin
            en[k] = '0;
            for (int j = 0; j < N_IN; j++) begin
                en[k][j] = (field == SEL_W'(j));
            end
        end
    end

endmodule

// File: rtl/xbar_or_plane.sv
module xbar_or_plane #(
    parameter int unsigned N_IN  = 16,
    parameter int unsigned N_OUT = 8
) (
    input  logic [N_IN-1:0]             din,
    input  logic [N_OUT-1:0][N_IN-1:0]  en,
    output logic [N_OUT-1:0]            dout
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign dout[k] = |(en[k] & din);
    end

endmodule

// File: rtl/ctx_xbar.sv
module ctx_xbar
    import xbar_pkg::*;
#(
    parameter int unsigned N_IN  = DEF_N_IN,
    parameter int unsigned N_OUT = DEF_N_OUT,
    parameter int unsigned N_CTX = DEF_N_CTX,
    localparam int unsigned SEL_W = sel_width(N_IN),
    localparam int unsigned CFG_W = N_OUT * SEL_W,
    localparam int unsigned CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] ctx_sel,
    input  logic [N_IN-1:0]  din,
    input  logic             prog_we,
    input  logic [CTX_W-1:0] prog_ctx,
    input  logic [CFG_W-1:0] prog_word,
    output logic [N_OUT-1:0] dout
);

    logic [CFG_W-1:0]            act_word;
    logic [N_OUT-1:0][N_IN-1:0]  sel_en;

    xbar_cfg_store #(
        .N_CTX (N_CTX),
        .CFG_W (CFG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_we),
        .wr_ctx  (prog_ctx),
        .wr_word (prog_word),
        .rd_ctx  (ctx_sel),
        .rd_word (act_word)
    );

    xbar_sel_decode #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .SEL_W (SEL_W)
    ) u_dec (
        .word (act_word),
        .en   (sel_en)
    );

    xbar_or_plane #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT)
    ) u_or (
        .din  (din),
        .en   (sel_en),
        .dout (dout)
    );

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
    parameter int unsigned N_IN  = 16,
    parameter int unsigned N_OUT = 8,
    parameter int unsigned SEL_W = 4,
    parameter int unsigned CTX_W = 2,
    localparam int unsigned CFG_W = N_OUT * SEL_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CTX_W-1:0]            ctx_sel,
    input logic [N_IN-1:0]             din,
    input logic                        prog_we,
    input logic [CTX_W-1:0]            prog_ctx,
    input logic [CFG_W-1:0]            prog_word,
    input logic [N_OUT-1:0]            dout,
    input logic [N_OUT-1:0][N_IN-1:0]  sel_en
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(sel_en[k]) == 1); // R6

        AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            prog_we |=> ((ctx_sel != $past(prog_ctx)) ||
                         (dout[k] == din[$past(prog_word[k*SEL_W +: SEL_W])]))); // R4
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_we |=> (!$stable(ctx_sel) || !$stable(din) || $stable(dout))); // R7

    AST_OTHER_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && (prog_ctx != ctx_sel))
            |=> (!$stable(ctx_sel) || !$stable(din) || $stable(dout))); // R5

endmodule

bind ctx_xbar xbar_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .SEL_W (SEL_W),
    .CTX_W (CTX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctx_sel   (ctx_sel),
    .din       (din),
    .prog_we   (prog_we),
    .prog_ctx  (prog_ctx),
    .prog_word (prog_word),
    .dout      (dout),
    .sel_en    (sel_en)
);

// File: tb/tb_ctx_xbar.sv
`timescale 1ns/1ps
module tb_ctx_xbar;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ctx_sel;
    logic [15:0] din;
    logic        prog_we;
    logic [1:0]  prog_ctx;
    logic [31:0] prog_word;
    logic [7:0]  dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ctx_xbar dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctx_sel   (ctx_sel),
        .din       (din),
        .prog_we   (prog_we),
        .prog_ctx  (prog_ctx),
        .prog_word (prog_word),
        .dout      (dout)
    );

    function automatic logic [7:0] route(input logic [31:0] w, input logic [15:0] d);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = d[w[4*k +: 4]];
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected=%h (ctx=%0d din=%h)", req, dout, exp, ctx_sel, din);
        end
    endtask

    task automatic write_cfg(input logic [1:0] c, input logic [31:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_ctx = c; prog_word = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    localparam logic [31:0] W0 = 32'h7654_3210;
    localparam logic [31:0] W1 = 32'hFDB9_7531;
    localparam logic [31:0] W2 = 32'h0F1E_2D3C;
    localparam logic [31:0] W3 = 32'h8899_AABB;

    task automatic t_reset();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            ctx_sel = 2'(c);
            din = 16'h0001; #1 check("R1", 8'hFF);
            din = 16'hFFFE; #1 check("R1", 8'h00);
        end
    endtask

    task automatic t_fields();
        write_cfg(2'd0, W0);
        ctx_sel = 2'd0;
        foreach (din[i]) begin end
        for (int p = 0; p < 6; p++) begin
            din = 16'(16'hA5C3 * (p + 3) ^ (p << 7));
            #1 check("R2", route(W0, din));
        end
    endtask

    task automatic t_walk_one();
        write_cfg(2'd1, W1);
        @(negedge clk);
        ctx_sel = 2'd1;
        for (int j = 0; j < 16; j++) begin
            din = 16'(1 << j);
            #1 check("R6", route(W1, din));
        end
    endtask

    task automatic t_ctx_switch();
        write_cfg(2'd2, W2);
        write_cfg(2'd3, W3);
        din = 16'h3C5A;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ctx_sel = 2'(i % 4);
            #1;
            case (i % 4)
                0: check("R3", route(W0, din));
                1: check("R3", route(W1, din));
                2: check("R3", route(W2, din));
                default: check("R3", route(W3, din));
            endcase
        end
    endtask

    task automatic t_write_active();
        logic [31:0] nw;
        nw = 32'h1234_5678;
        @(negedge clk);
        ctx_sel = 2'd2; din = 16'hC3A5;
        prog_we = 1'b1; prog_ctx = 2'd2; prog_word = nw;
        #1 check("R4 before edge", route(W2, din));
        @(negedge clk);
        prog_we = 1'b0;
        #1 check("R4 after edge", route(nw, din));
        write_cfg(2'd2, W2);
        #1 check("R4 restore", route(W2, din));
    endtask

    task automatic t_isolation();
        @(negedge clk);
        ctx_sel = 2'd0; din = 16'h96E1;
        prog_we = 1'b1; prog_ctx = 2'd3; prog_word = 32'h0;
        #1 check("R5 active during write", route(W0, din));
        @(negedge clk);
        prog_we = 1'b0;
        #1 check("R5 active after write", route(W0, din));
        ctx_sel = 2'd1; #1 check("R5 ctx1 kept", route(W1, din));
        ctx_sel = 2'd2; #1 check("R5 ctx2 kept", route(W2, din));
        ctx_sel = 2'd3; #1 check("R5 ctx3 written", route(32'h0, din));
        write_cfg(2'd3, W3);
    endtask

    task automatic t_hold();
        @(negedge clk);
        ctx_sel = 2'd3; din = 16'h5AA5;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1 check("R7", route(W3, din));
        end
    endtask

    task automatic t_comb();
        @(negedge clk);
        ctx_sel = 2'd0;
        din = 16'h0000; #1 check("R8", route(W0, din));
        din = 16'h00F0; #1 check("R8", route(W0, din));
        din = 16'hFF0F; #1 check("R8", route(W0, din));
    endtask

    task automatic t_broadcast();
        write_cfg(2'd1, 32'h7777_7777);
        ctx_sel = 2'd1;
        din = 16'h0080; #1 check("R9", 8'hFF);
        din = 16'hFF7F; #1 check("R9", 8'h00);
        write_cfg(2'd1, W1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctx_sel = '0; din = '0;
        prog_we = 1'b0; prog_ctx = '0; prog_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_walk_one();
        t_ctx_switch();
        t_write_active();
        t_isolation();
        t_hold();
        t_comb();
        t_broadcast();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule